// File: doc/BRIEF.md
# Prescaled Match Timer

The block is a timer peripheral that produces periodic and one-shot interrupts. A prescale counter divides the block clock. Each time the prescale counter rolls over, the timer counter advances by one. Four match channels compare the timer counter with their own match values. On a match, a channel can raise its interrupt flag, send the timer counter back to zero, or stop the timer. One channel with its reset action set defines the period. The other channels share the same counter and flag their own points within that period.

Software controls the block through a single-cycle register bus. Writes take effect on the clock edge that samples `bus_wr`. Reads are combinational from `bus_addr`. The counter-control register is held by a four-state machine whose encoding is the register's two bits: `ST_IDLE` (00), `ST_RUN` (01), `ST_HOLD` (10) and `ST_HOLD_ARMED` (11).

Transitions of the state machine:
- A control write moves the machine from any state to the state that matches the written bits. These are the arcs `IDLE->RUN`, `RUN->IDLE`, `any->HOLD`, `any->HOLD_ARMED` and `HOLD_ARMED->RUN`.
- A stop-on-match in `ST_RUN` takes the arc `RUN->IDLE`.
- A control write in the same cycle as a stop-on-match takes precedence over the stop.

Register map (4-bit word address):
- 0 `CTRL`: bit0 run, bit1 hold.
- 1 `PSC`: the prescale value.
- 2 `ACT`: the per-channel action bits.
- 3 `FLAG`: the interrupt flags, bit k for channel k, write one to clear.
- 4 `TCNT`: the timer counter, read only.
- 5 `PCNT`: the prescale counter, read only.
- 8+k `MATCHk`: the match value of channel k.

Top module: `match_tick_timer`

## Requirements
- R1: After reset, every register and both counters read 0 and `irq` is low.
- R2: While `CTRL` bit0 (run) is 0 and bit1 (hold) is 0, neither counter changes.
- R3: With `PSC`=P and the timer running, `PCNT` counts 0..P. `TCNT` advances by one on each clock where `PCNT` has reached P. So n clocks after the run write, `TCNT`=n/(P+1) and `PCNT`=n mod (P+1).
- R4: `ACT` bit 3k+1 (reset-on-match) makes `TCNT` go to 0 instead of advancing when it equals `MATCHk` at an advance. `TCNT` therefore wraps through 0..M.
- R5: `ACT` bit 3k (interrupt-on-match) sets `FLAG` bit k at such a match. `irq` is high while any `FLAG` bit is set.
- R6: `ACT` bit 3k+2 (stop-on-match) halts both counters at the match, leaving `TCNT` at the match value and `PCNT` at 0, and makes `CTRL` bit0 read 0.
- R7: Writing 1 to a `FLAG` bit clears it and writing 0 leaves it unchanged. A new match in the same cycle as the clear keeps the flag set.
- R8: While one channel resets the shared counter, another channel with a lower match value still flags its own match within every period.
- R9: A match is evaluated only on the clock where `TCNT` is about to advance. The flag for value M therefore appears (M+1)(P+1) clocks after the run write and not earlier.
- R10: While `CTRL` bit1 (hold) is set, both counters are forced to 0. After hold is released with run set, counting restarts from 0.
- R11: A match on a channel whose interrupt-on-match bit is 0 leaves its `FLAG` bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | OR of all interrupt flags |

## Verification
Random prescale values and run lengths check the free-running count against n/(P+1) and n mod (P+1). This separates an off-by-one in the prescale comparison from an off-by-one in the counter step. Random prescale and match pairs with reset-on-match check the wrap point and the instant of the first flag, which exposes a period of M instead of M+1 counts. Directed cases cover the remaining behaviour:
- A long prescale period shows whether the match fires early, on the first clock of the matched value, rather than at the advance.
- A stop case checks the frozen counters and the cleared run bit.
- A shared-counter case lines a write-one-to-clear up with a new match in the same clock to check that the set is kept.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
    localparam int AW = 4;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_RUN        = 2'b01,
        ST_HOLD       = 2'b10,
        ST_HOLD_ARMED = 2'b11
    } tmr_state_e;

    localparam logic [AW-1:0] A_CTRL  = 4'd0;
    localparam logic [AW-1:0] A_PSC   = 4'd1;
    localparam logic [AW-1:0] A_ACT   = 4'd2;
    localparam logic [AW-1:0] A_FLAG  = 4'd3;
    localparam logic [AW-1:0] A_TCNT  = 4'd4;
    localparam logic [AW-1:0] A_PCNT  = 4'd5;
    localparam logic [AW-1:0] A_MATCH = 4'd8;

    // action bit offsets inside one channel's 3-bit group
    localparam int ACT_IRQ  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_STOP = 2;
    localparam int ACT_W    = 3;
endpackage

// File: rtl/mtt_ctrl_fsm.sv
module mtt_ctrl_fsm
    import mtt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    input  logic       stop_hit,
    output logic       running,
    output logic       holding,
    output logic [1:0] ctrl_rd
);
    tmr_state_e st_q, st_d, st_wr;

    always_comb begin
        unique case (ctrl_wdata)
            2'b00:   st_wr = ST_IDLE;
            2'b01:   st_wr = ST_RUN;
            2'b10:   st_wr = ST_HOLD;
            default: st_wr = ST_HOLD_ARMED;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (ctrl_wr)       st_d = st_wr;
                else if (stop_hit) st_d = ST_IDLE;
            end
            ST_IDLE, ST_HOLD, ST_HOLD_ARMED: begin
                if (ctrl_wr) st_d = st_wr;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        running = 1'b0;
        holding = 1'b0;
        ctrl_rd = 2'b00;
        unique case (st_q)
            ST_IDLE:       ctrl_rd = 2'b00;
            ST_RUN:        begin running = 1'b1; ctrl_rd = 2'b01; end
            ST_HOLD:       begin holding = 1'b1; ctrl_rd = 2'b10; end
            ST_HOLD_ARMED: begin holding = 1'b1; ctrl_rd = 2'b11; end
            default:       ctrl_rd = 2'b00;
        endcase
    end
endmodule

// File: rtl/mtt_prescaler.sv
module mtt_prescaler #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          holding,
    input  logic [DW-1:0] psc,
    output logic [DW-1:0] pcnt,
    output logic          tick
);
    // >= keeps the divider bounded if PSC is lowered below the running count
    assign tick = running && (pcnt >= psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pcnt <= '0;
        else if (holding) pcnt <= '0;
        else if (running) pcnt <= tick ? '0 : pcnt + DW'(1);
    end
endmodule

// File: rtl/mtt_match_chan.sv
module mtt_match_chan
    import mtt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]    tcnt,
    input  logic [DW-1:0]    mval,
    input  logic             tick,
    input  logic [ACT_W-1:0] act,
    output logic             hit_irq,
    output logic             hit_rst,
    output logic             hit_stop
);
    logic hit;
    assign hit      = tick && (tcnt == mval);
    assign hit_irq  = hit && act[ACT_IRQ];
    assign hit_rst  = hit && act[ACT_RST];
    assign hit_stop = hit && act[ACT_STOP];
endmodule

// File: rtl/match_tick_timer.sv
module match_tick_timer
    import mtt_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int ACTW = ACT_W * NCH;

    logic [DW-1:0]   psc_q;
    logic [ACTW-1:0] act_q;
    logic [DW-1:0]   mval_q [NCH];
    logic [NCH-1:0]  flags_q;
    logic [DW-1:0]   tcnt_q;
    logic [DW-1:0]   pcnt_q;
    logic            running, holding, tick;
    logic [1:0]      ctrl_rd;
    logic [NCH-1:0]  irq_hit, rst_hit, stop_hit;
    logic            any_rst, any_stop;
    logic            wr_ctrl, wr_flag;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_flag = bus_wr && (bus_addr == A_FLAG);

    mtt_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wdata (bus_wdata[1:0]),
        .stop_hit   (any_stop),
        .running    (running),
        .holding    (holding),
        .ctrl_rd    (ctrl_rd)
    );

    mtt_prescaler #(.DW(DW)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .holding (holding),
        .psc     (psc_q),
        .pcnt    (pcnt_q),
        .tick    (tick)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        mtt_match_chan #(.DW(DW)) u_chan (
            .tcnt     (tcnt_q),
            .mval     (mval_q[k]),
            .tick     (tick),
            .act      (act_q[ACT_W*k +: ACT_W]),
            .hit_irq  (irq_hit[k]),
            .hit_rst  (rst_hit[k]),
            .hit_stop (stop_hit[k])
        );
    end

    assign any_rst  = |rst_hit;
    assign any_stop = |stop_hit;

    // timer counter: reset action beats stop, stop freezes the value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tcnt_q <= '0;
        else if (holding)  tcnt_q <= '0;
        else if (tick) begin
            if (any_rst)       tcnt_q <= '0;
            else if (!any_stop) tcnt_q <= tcnt_q + DW'(1);
        end
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
            act_q <= '0;
            for (int k = 0; k < NCH; k++) mval_q[k] <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_PSC) psc_q <= bus_wdata;
            if (bus_addr == A_ACT) act_q <= bus_wdata[ACTW-1:0];
            for (int k = 0; k < NCH; k++)
                if (bus_addr == A_MATCH + AW'(k)) mval_q[k] <= bus_wdata;
        end
    end

    // flags: a new match wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(wr_flag ? bus_wdata[NCH-1:0] : '0)) | irq_hit;
    end

    assign irq = |flags_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DW'(ctrl_rd);
            A_PSC:   bus_rdata = psc_q;
            A_ACT:   bus_rdata = DW'(act_q);
            A_FLAG:  bus_rdata = DW'(flags_q);
            A_TCNT:  bus_rdata = tcnt_q;
            A_PCNT:  bus_rdata = pcnt_q;
            default: begin
                for (int k = 0; k < NCH; k++)
                    if (bus_addr == A_MATCH + AW'(k)) bus_rdata = mval_q[k];
            end
        endcase
    end
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker
    import mtt_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic           running,
    input logic           holding,
    input logic           tick,
    input logic           any_rst,
    input logic           any_stop,
    input logic [1:0]     ctrl_rd,
    input logic [DW-1:0]  tcnt_q,
    input logic [DW-1:0]  pcnt_q,
    input logic [NCH-1:0] flags_q
);
    p_idle_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !holding) |=> ($stable(tcnt_q) && $stable(pcnt_q)));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !any_rst && !any_stop && !holding) |=> (tcnt_q == $past(tcnt_q) + DW'(1)));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && any_rst) |=> (tcnt_q == '0));

    p_stop_clears_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && any_stop && !(bus_wr && bus_addr == A_CTRL)) |=> (ctrl_rd[0] == 1'b0));

    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_FLAG) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        holding |=> (tcnt_q == '0 && pcnt_q == '0));
endmodule

bind match_tick_timer mtt_checker #(.DW(DW), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .running  (running),
    .holding  (holding),
    .tick     (tick),
    .any_rst  (any_rst),
    .any_stop (any_stop),
    .ctrl_rd  (ctrl_rd),
    .tcnt_q   (tcnt_q),
    .pcnt_q   (pcnt_q),
    .flags_q  (flags_q)
);

// File: tb/match_tick_timer_tb.sv
`timescale 1ns/1ps
module match_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          errors = 0;
    int          checks = 0;

    localparam logic [3:0] RA_CTRL = 4'd0, RA_PSC = 4'd1, RA_ACT = 4'd2, RA_FLAG = 4'd3,
                           RA_TCNT = 4'd4, RA_PCNT = 4'd5, RA_M0 = 4'd8;

    always #2.5 clk = ~clk;

    match_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int unsigned f_tcnt(int unsigned n, int unsigned p);
        return n / (p + 1);
    endfunction
    function automatic int unsigned f_pcnt(int unsigned n, int unsigned p);
        return n % (p + 1);
    endfunction
    function automatic int unsigned f_wrap(int unsigned n, int unsigned p, int unsigned m);
        return (n / (p + 1)) % (m + 1);
    endfunction
    function automatic int unsigned f_flag(int unsigned n, int unsigned p, int unsigned m);
        return (n >= (m + 1) * (p + 1)) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #0.1; d = bus_rdata;
    endtask

    task automatic wait_n(input int unsigned n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [31:0] p, input logic [31:0] act,
                         input logic [31:0] m0, input logic [31:0] m1,
                         input logic [31:0] m2, input logic [31:0] m3);
        wr(RA_CTRL, 32'd2);
        wr(RA_PSC, p);
        wr(RA_ACT, act);
        wr(RA_M0, m0);
        wr(RA_M0 + 4'd1, m1);
        wr(RA_M0 + 4'd2, m2);
        wr(RA_M0 + 4'd3, m3);
        wr(RA_FLAG, 32'hF);
        wr(RA_CTRL, 32'd1);
    endtask

    initial begin
        #(200000 * 5.0);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(RA_CTRL, v); chk("R1 ctrl", v, 0);
        rd(RA_PSC, v);  chk("R1 psc", v, 0);
        rd(RA_FLAG, v); chk("R1 flag", v, 0);
        rd(RA_TCNT, v); chk("R1 tcnt", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 no counting before run
        wait_n(10);
        rd(RA_TCNT, v); chk("R2 tcnt idle", v, 0);
        rd(RA_PCNT, v); chk("R2 pcnt idle", v, 0);

        // R3 random free running
        for (int i = 0; i < 6; i++) begin
            int unsigned p = $urandom_range(0, 5);
            int unsigned n = $urandom_range(0, 60);
            start(p, 0, 0, 0, 0, 0);
            wait_n(n);
            rd(RA_TCNT, v); chk("R3 tcnt", v, f_tcnt(n, p));
            rd(RA_PCNT, v); chk("R3 pcnt", v, f_pcnt(n, p));
        end

        // R4/R5 random wrap with flag on channel 0
        for (int i = 0; i < 6; i++) begin
            int unsigned p = $urandom_range(0, 3);
            int unsigned m = $urandom_range(0, 7);
            int unsigned n = $urandom_range(0, 80);
            start(p, 32'h3, m, 0, 0, 0);
            wait_n(n);
            rd(RA_TCNT, v); chk("R4 tcnt wrap", v, f_wrap(n, p, m));
            rd(RA_FLAG, v); chk("R5 flag0", v, f_flag(n, p, m));
            chk("R5 irq", {31'd0, irq}, f_flag(n, p, m));
        end

        // R9 match only at the advance: P=9, ch2 irq only, M=2
        start(9, 32'h40, 100, 100, 2, 100);
        wait_n(29);
        rd(RA_FLAG, v); chk("R9 no early flag", v, 0);
        wait_n(1);
        rd(RA_FLAG, v); chk("R9 flag at advance", v, 32'h4);
        rd(RA_TCNT, v); chk("R9 tcnt", v, 3);

        // R8/R7 shared counter: ch0 irq+reset M=4, ch1 irq M=2, P=0
        start(0, 32'h0B, 4, 2, 100, 100);
        wait_n(5);
        rd(RA_FLAG, v); chk("R8 both flags", v, 32'h3);
        rd(RA_TCNT, v); chk("R8 tcnt wrapped", v, 0);
        wr(RA_FLAG, 32'h0);
        rd(RA_FLAG, v); chk("R7 write zero keeps", v, 32'h3);
        wr(RA_FLAG, 32'h1);
        rd(RA_FLAG, v); chk("R7 clear bit0", v, 32'h2);
        chk("R5 irq one flag", {31'd0, irq}, 1);
        wr(RA_FLAG, 32'h2);
        rd(RA_FLAG, v); chk("R7 set wins over clear", v, 32'h2);
        wr(RA_CTRL, 32'd0);
        wr(RA_FLAG, 32'h3);
        rd(RA_FLAG, v); chk("R7 cleared", v, 0);
        chk("R5 irq low", {31'd0, irq}, 0);

        // R6/R11 stop on ch1 M=3 with irq, ch3 M=1 no action, P=1
        start(1, 32'h28, 100, 3, 100, 1);
        wait_n(10);
        rd(RA_TCNT, v); chk("R6 tcnt stopped", v, 3);
        rd(RA_PCNT, v); chk("R6 pcnt stopped", v, 0);
        rd(RA_CTRL, v); chk("R6 run cleared", v, 0);
        rd(RA_FLAG, v); chk("R11 only ch1 flag", v, 32'h2);
        wait_n(5);
        rd(RA_TCNT, v); chk("R2 stays after stop", v, 3);

        // R10 hold
        wr(RA_CTRL, 32'd3);
        wait_n(1);
        rd(RA_TCNT, v); chk("R10 tcnt held", v, 0);
        rd(RA_PCNT, v); chk("R10 pcnt held", v, 0);
        rd(RA_CTRL, v); chk("R10 ctrl", v, 3);
        wr(RA_CTRL, 32'd1);
        wait_n(3);
        rd(RA_TCNT, v); chk("R10 restart tcnt", v, 1);
        rd(RA_PCNT, v); chk("R10 restart pcnt", v, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule